// File: doc/BRIEF.md
# Double-Buffered Display Configuration Bank

This block holds the configuration words of a display pipeline in two copies. A CPU-side port writes and reads a shadow copy. The pixel pipeline sees only the active copy, and the active copy changes only on a cycle where the vertical-blanking pulse is high. Every transfer copies the whole bank at once, so the pipeline never sees half of an update.

Two control bits decide whether a vblank transfers. An auto-load-off bit stops the automatic copy on every frame. When that bit is set, software stages its writes and then sets a commit bit. The commit bit reads back as 1 until the next vblank has copied the bank, and then hardware clears it. Software polls this bit before it starts the next batch of writes. When auto-load is on, every vblank transfers, whether or not a commit is pending.

The port is word addressed. Addresses 0 to NUM_REGS-1 select configuration words. Address NUM_REGS selects the control word. The configuration words have no reset value, so software must write each of them before its first commit. A separate debug read port returns words from the active copy.

Top module: `dbuf_cfg_bank`

## Requirements
- R1: After reset, the control word reads 0x2: the commit bit (bit 0) is 0 and the auto-load-off bit (bit 1) is 1.
- R2: A write to address i < NUM_REGS can be read at rd_addr = i from the following cycle. It does not change the active copy.
- R3: While auto-load is off and no commit is pending, a vblank leaves every active word unchanged.
- R4: Writing the control word with bit 0 set makes bit 0 read 1 from the next cycle. It stays 1 through all cycles that have no vblank.
- R5: On a vblank cycle with a commit pending, every active word takes its shadow value, visible on the following cycle. The commit bit reads 0 from that cycle, unless a new commit was written in the same cycle.
- R6: Writing the control word with bit 0 clear does not cancel a pending commit.
- R7: With bit 1 of the control word at 0 (auto-load on), every vblank copies the shadow bank to the active bank, with no commit written.
- R8: A configuration write in the same cycle as a transferring vblank goes into the shadow copy. The value it overwrites is the one that reaches the active copy.
- R9: A commit written in the same cycle as a vblank is not served by that vblank. It stays pending and is served by the next one.
- R10: dbg_data returns the active word selected by dbg_addr. active_regs carries word i in bits [i*DATA_W +: DATA_W].
- R11: Writes to addresses above NUM_REGS are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the CPU port |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the CPU read |
| rd_data | output | DATA_W | Shadow word or control word, combinational from rd_addr |
| vblank | input | 1 | One-cycle vertical blanking pulse |
| dbg_addr | input | ADDR_W | Word address of the debug read |
| dbg_data | output | DATA_W | Active word at dbg_addr, combinational |
| active_regs | output | NUM_REGS*DATA_W | Active copy as seen by the pixel pipeline |

## Verification
Each write and each vblank goes through one register stage. A shadow value, the control bits and a transferred active value therefore all change at the clock edge where the strobe is sampled. The read ports are combinational, so the new value can be read before the following edge. The bench drives the strobes on falling edges and drops them one half-period after the rising edge that samples them. It then reads the ports before the next rising edge, which is the first point where the result is due. The same-cycle cases (R8, R9) drive the write and the vblank in the same half-period. They then look at both the shadow copy and the active copy after one vblank, and again after a second vblank.

// File: rtl/dbuf_cfg_pkg.sv
package dbuf_cfg_pkg;
  localparam int CTL_COMMIT_BIT = 0;
  localparam int CTL_AUTOOFF_BIT = 1;
  localparam int CTL_WIDTH = 2;
endpackage

// File: rtl/dbuf_cfg_shadow.sv
module dbuf_cfg_shadow #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_word,
  output logic [NUM_REGS*DATA_W-1:0]   shadow_flat
);
  logic [DATA_W-1:0] word_q [NUM_REGS];
  logic [NUM_REGS-1:0] word_en;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      word_en[i] = wr_en && (32'(wr_addr) == i);
    end
  end

  // datapath flops: no reset, software initialises every word
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (word_en[i]) word_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (32'(rd_addr) == i) rd_word = word_q[i];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign shadow_flat[g*DATA_W +: DATA_W] = word_q[g];
  end
endmodule

// File: rtl/dbuf_cfg_active.sv
module dbuf_cfg_active #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         xfer,
  input  logic [NUM_REGS*DATA_W-1:0]   shadow_flat,
  input  logic [ADDR_W-1:0]            dbg_addr,
  output logic [DATA_W-1:0]            dbg_word,
  output logic [NUM_REGS*DATA_W-1:0]   active_flat
);
  logic [DATA_W-1:0] act_q [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (xfer) act_q[i] <= shadow_flat[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    dbg_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (32'(dbg_addr) == i) dbg_word = act_q[i];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign active_flat[g*DATA_W +: DATA_W] = act_q[g];
  end

  AST_XFER_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> active_flat == $past(shadow_flat)); // R5
  AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(active_flat)); // R3
endmodule

// File: rtl/dbuf_cfg_ctrl.sv
module dbuf_cfg_ctrl
  import dbuf_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic set_commit,
  input  logic set_autooff,
  input  logic vblank,
  output logic commit_q,
  output logic autooff_q,
  output logic xfer
);
  logic commit_d, autooff_d;

  assign xfer = vblank && (commit_q || !autooff_q);

  always_comb begin
    commit_d = commit_q;
    if (ctl_wr && set_commit) commit_d = 1'b1;
    else if (xfer) commit_d = 1'b0;
    autooff_d = ctl_wr ? set_autooff : autooff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q  <= 1'b0;
      autooff_q <= 1'b1;
    end else begin
      commit_q  <= commit_d;
      autooff_q <= autooff_d;
    end
  end

  AST_COMMIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q && !vblank |=> commit_q); // R4
  AST_NEW_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && set_commit |=> commit_q); // R9
  AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q && vblank && !(ctl_wr && set_commit) |=> !commit_q); // R5
endmodule

// File: rtl/dbuf_cfg_bank.sv
module dbuf_cfg_bank
  import dbuf_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NUM_REGS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        vblank,
  input  logic [ADDR_W-1:0]           dbg_addr,
  output logic [DATA_W-1:0]           dbg_data,
  output logic [NUM_REGS*DATA_W-1:0]  active_regs
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_REGS);

  logic rst_meta_q, rst_sync_q;
  logic [DATA_W-1:0] shadow_word;
  logic [NUM_REGS*DATA_W-1:0] shadow_flat;
  logic commit_q, autooff_q, xfer, ctl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign ctl_wr = wr_en && (wr_addr == CTL_ADDR);

  dbuf_cfg_shadow #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(shadow_word), .shadow_flat(shadow_flat)
  );

  dbuf_cfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .ctl_wr(ctl_wr),
    .set_commit(wr_data[CTL_COMMIT_BIT]), .set_autooff(wr_data[CTL_AUTOOFF_BIT]),
    .vblank(vblank), .commit_q(commit_q), .autooff_q(autooff_q), .xfer(xfer)
  );

  dbuf_cfg_active #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_active (
    .clk(clk), .rst_n(rst_sync_q), .xfer(xfer), .shadow_flat(shadow_flat),
    .dbg_addr(dbg_addr), .dbg_word(dbg_data), .active_flat(active_regs)
  );

  always_comb begin
    if (32'(rd_addr) < NUM_REGS) rd_data = shadow_word;
    else if (rd_addr == CTL_ADDR) rd_data = DATA_W'({autooff_q, commit_q});
    else rd_data = '0;
  end

  AST_AUTOLOAD_EVERY_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_q)
    vblank && !autooff_q |=> active_regs == $past(shadow_flat)); // R7
  AST_IDLE_VBLANK_NO_COPY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    vblank && autooff_q && !commit_q |=> $stable(active_regs)); // R3
  AST_WRITE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wr_en && !vblank |=> $stable(active_regs)); // R2
endmodule

// File: tb/dbuf_cfg_bank_bench.sv
module dbuf_cfg_bank_bench;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = $clog2(NR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic vblank = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_data;
  logic [NR*DW-1:0] active_regs;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] sh_m [NR];
  logic [DW-1:0] ac_m [NR];

  always #4 clk = ~clk;

  dbuf_cfg_bank #(.NUM_REGS(NR), .DATA_W(DW)) u_dbuf_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vblank(vblank),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .active_regs(active_regs)
  );

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
  endtask

  task automatic write_with_vblank(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; vblank = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; vblank = 1'b0;
  endtask

  task automatic cpu_read(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1;
    d = rd_data;
  endtask

  task automatic check_active(input string req);
    for (int i = 0; i < NR; i++) begin
      dbg_addr = AW'(i);
      #1;
      check(req, $sformatf("dbg word %0d", i), dbg_data, ac_m[i]);
      check(req, $sformatf("active_regs word %0d", i), active_regs[i*DW +: DW], ac_m[i]);
    end
  endtask

  task automatic check_shadow(input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < NR; i++) begin
      cpu_read(i, v);
      check(req, $sformatf("shadow word %0d", i), v, sh_m[i]);
    end
  endtask

  task automatic check_ctl(input string req, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    cpu_read(NR, v);
    check(req, "control word", v, exp);
  endtask

  task automatic t_reset();
    check_ctl("R1", 32'h2);
  endtask

  task automatic t_first_commit();
    for (int i = 0; i < NR; i++) begin
      sh_m[i] = 32'hA500_0000 + DW'(i * 17);
      cpu_write(i, sh_m[i]);
    end
    check_shadow("R2");
    cpu_write(NR, 32'h3);
    check_ctl("R4", 32'h3);
    repeat (3) @(negedge clk);
    check_ctl("R4", 32'h3);
    pulse_vblank();
    for (int i = 0; i < NR; i++) ac_m[i] = sh_m[i];
    check_ctl("R5", 32'h2);
    check_active("R5 R10");
  endtask

  task automatic t_hold_without_commit();
    for (int i = 0; i < NR; i++) begin
      sh_m[i] = 32'h0B00_1000 ^ DW'(i << 4);
      cpu_write(i, sh_m[i]);
    end
    check_active("R2");
    pulse_vblank();
    check_active("R3");
    check_shadow("R3");
  endtask

  task automatic t_no_cancel();
    cpu_write(NR, 32'h3);
    cpu_write(NR, 32'h2);
    check_ctl("R6", 32'h3);
    check_active("R6");
    pulse_vblank();
    for (int i = 0; i < NR; i++) ac_m[i] = sh_m[i];
    check_active("R6");
    check_ctl("R6", 32'h2);
  endtask

  task automatic t_autoload();
    cpu_write(NR, 32'h0);
    check_ctl("R7", 32'h0);
    sh_m[0] = 32'hC0C0_0001;
    cpu_write(0, sh_m[0]);
    pulse_vblank();
    ac_m[0] = sh_m[0];
    check_active("R7");
    sh_m[5] = 32'hD00D_0005;
    cpu_write(5, sh_m[5]);
    pulse_vblank();
    ac_m[5] = sh_m[5];
    check_active("R7");
  endtask

  task automatic t_write_during_vblank();
    write_with_vblank(1, 32'hEEEE_1111);
    for (int i = 0; i < NR; i++) ac_m[i] = sh_m[i];
    sh_m[1] = 32'hEEEE_1111;
    check_active("R8");
    check_shadow("R8");
    pulse_vblank();
    ac_m[1] = sh_m[1];
    check_active("R8");
  endtask

  task automatic t_commit_during_vblank();
    cpu_write(NR, 32'h2);
    sh_m[3] = 32'h3333_F00D;
    cpu_write(3, sh_m[3]);
    write_with_vblank(NR, 32'h3);
    check_ctl("R9", 32'h3);
    check_active("R9");
    pulse_vblank();
    ac_m[3] = sh_m[3];
    check_ctl("R9", 32'h2);
    check_active("R9");
  endtask

  task automatic t_out_of_range();
    logic [DW-1:0] v;
    cpu_write((1 << AW) - 1, 32'hFFFF_FFFF);
    check_shadow("R11");
    check_ctl("R11", 32'h2);
    cpu_read((1 << AW) - 1, v);
    check("R11", "unmapped read", v, 32'h0);
  endtask

  initial begin
    #50000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_commit();
    t_hold_without_commit();
    t_no_cancel();
    t_autoload();
    t_write_during_vblank();
    t_commit_during_vblank();
    t_out_of_range();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule